// File: doc/BRIEF.md
# Long Copy Splitter and Completion Tracker

This block sits between a requester and a copy engine that can only move a bounded number of bytes per transfer. It takes one copy request at a time (source address, destination address, total byte count), cuts it into consecutive segments no longer than the engine limit, and pushes those segments into a small in-order queue. A launch sequencer drains the queue one segment at a time: it waits for the engine to go idle, pulses a warm reset, waits for idle again, then starts the engine with the head segment. Each engine completion retires the head segment and, if more are queued, begins the next launch at once.

A tracker holds the residue of the whole request. It is loaded with the total length when the request is accepted and is reduced by each segment's length as that segment completes. The request-complete pulse fires only when the residue reaches zero. A zero-length request completes on the following cycle and never touches the engine. A new request is accepted only when the previous one has fully completed.

Splitter states: `S_IDLE` (waiting for a request; on a non-zero request go to `S_CUT`) and `S_CUT` (push one segment per cycle while the queue has room; return to `S_IDLE` after pushing the last one). Launcher states: `L_IDLE` → `L_WAIT_IDLE` when the queue is not empty; `L_WAIT_IDLE` → `L_WARM` when the engine is idle; `L_WARM` → `L_WARM_WAIT` always; `L_WARM_WAIT` → `L_START` when the engine is idle; `L_START` → `L_RUN` always; `L_RUN` → `L_WAIT_IDLE` on completion when more segments are queued, or `L_IDLE` on completion when the completed segment was the last one queued.

Top module: `long_copy_splitter`

## Requirements
- R1: A request of length L > 0 produces exactly ceil(L / SEG_MAX) engine starts. No segment is lost or duplicated when the queue fills and the splitter has to stall.
- R2: Segment k carries the length min(SEG_MAX, bytes still unsplit). Every segment is non-zero and at most SEG_MAX.
- R3: The first segment uses the request's source and destination. Each later segment's source and destination both equal those of the previous segment plus the previous segment's length.
- R4: `residue` equals the total length in the cycle after acceptance. When the engine reports a completion, `residue` still holds the total minus the lengths of all earlier completed segments.
- R5: `cmp_done` pulses exactly once per non-zero request, one cycle after the last segment's completion. It never pulses on an intermediate segment.
- R6: Segments start in queue order with at most one in flight. No start is issued while the engine is busy.
- R7: Before every start, `eng_warm_rst` is pulsed while the engine is idle, and the start itself is issued only after the engine is idle again.
- R8: A zero-length request pulses `cmp_done` in the cycle after acceptance and issues no engine start or warm reset.
- R9: `req_ready` is low from acceptance until the request completes. A request presented while `req_ready` is low has no effect on the segments issued.
- R10: After reset, `req_ready` is high, `residue` is zero, and `cmp_done`, `eng_start` and `eng_warm_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Request accepted on a cycle where valid and ready are both high |
| req_src | input | AW | Request source address |
| req_dst | input | AW | Request destination address |
| req_len | input | LW | Request total byte count |
| eng_warm_rst | output | 1 | One-cycle warm reset pulse to the engine |
| eng_start | output | 1 | One-cycle start pulse; segment fields are valid with it |
| eng_src | output | AW | Segment source address |
| eng_dst | output | AW | Segment destination address |
| eng_len | output | LW | Segment byte count |
| eng_busy | input | 1 | Engine busy (running or resetting) |
| eng_done | input | 1 | One-cycle engine completion pulse |
| cmp_done | output | 1 | One-cycle whole-request completion pulse |
| residue | output | LW | Bytes of the current request not yet completed |

## Verification
The splitter is exercised with lengths that leave a short final segment, with an exact multiple of the segment limit, with a length below one segment, and with zero. These separate errors in the rounding of the segment count, in the final-segment length and in the empty-request path. A request spanning many segments on a two-entry queue forces the splitter to stall, which shows whether the full/push interaction loses or repeats segments. Residue samples taken at each engine completion, together with the count of completion pulses, tell a premature per-segment completion apart from a correct whole-request one. A second request driven while the first is in progress shows whether the input is really ignored.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    typedef enum logic {
        S_IDLE,
        S_CUT
    } split_st_e;

    typedef enum logic [2:0] {
        L_IDLE,
        L_WAIT_IDLE,
        L_WARM,
        L_WARM_WAIT,
        L_START,
        L_RUN
    } launch_st_e;

endpackage

// File: rtl/lcs_seg_fifo.sv
module lcs_seg_fifo #(
    parameter int W     = 96,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic         multi
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        rdata = mem[rp];
        empty = (cnt == '0);
        full  = (cnt == FULLC);
        multi = (cnt > CW'(1));
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R1
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6

endmodule

// File: rtl/lcs_splitter.sv
module lcs_splitter
    import lcs_pkg::*;
#(
    parameter int          AW      = 32,
    parameter int          LW      = 32,
    parameter int unsigned SEG_MAX = 268435455
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [AW-1:0]     req_src,
    input  logic [AW-1:0]     req_dst,
    input  logic [LW-1:0]     req_len,
    input  logic              q_full,
    output logic              push,
    output logic [2*AW+LW-1:0] seg_data,
    output logic              idle
);
    localparam logic [LW-1:0] SEGL = LW'(SEG_MAX);

    split_st_e     st;
    logic [AW-1:0] cur_src, cur_dst;
    logic [LW-1:0] remain;
    logic [LW-1:0] seg_len;

    always_comb seg_len = (remain > SEGL) ? SEGL : remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            cur_src <= '0;
            cur_dst <= '0;
            remain  <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (acc && req_len != '0) begin
                        cur_src <= req_src;
                        cur_dst <= req_dst;
                        remain  <= req_len;
                        st      <= S_CUT;
                    end
                end
                S_CUT: begin
                    if (!q_full) begin
                        cur_src <= cur_src + AW'(seg_len);
                        cur_dst <= cur_dst + AW'(seg_len);
                        remain  <= remain - seg_len;
                        if (remain == seg_len) st <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        push     = (st == S_CUT) && !q_full;
        seg_data = {cur_src, cur_dst, seg_len};
        idle     = (st == S_IDLE);
    end

    AST_SEG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (seg_data[LW-1:0] != '0 && seg_data[LW-1:0] <= SEGL)); // R2

endmodule

// File: rtl/lcs_launcher.sv
module lcs_launcher
    import lcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_empty,
    input  logic               q_multi,
    input  logic [2*AW+LW-1:0] head,
    output logic               pop,
    input  logic               eng_busy,
    input  logic               eng_done,
    output logic               eng_warm_rst,
    output logic               eng_start,
    output logic [AW-1:0]      eng_src,
    output logic [AW-1:0]      eng_dst,
    output logic [LW-1:0]      eng_len,
    output logic               seg_done,
    output logic [LW-1:0]      seg_len
);
    localparam int W = 2 * AW + LW;

    launch_st_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= L_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            L_IDLE:      if (!q_empty)  st_nx = L_WAIT_IDLE;
            L_WAIT_IDLE: if (!eng_busy) st_nx = L_WARM;
            L_WARM:                     st_nx = L_WARM_WAIT;
            L_WARM_WAIT: if (!eng_busy) st_nx = L_START;
            L_START:                    st_nx = L_RUN;
            L_RUN:       if (eng_done)  st_nx = q_multi ? L_WAIT_IDLE : L_IDLE;
            default:                    st_nx = L_IDLE;
        endcase
    end

    always_comb begin
        eng_warm_rst = (st == L_WARM);
        eng_start    = (st == L_START);
        eng_src      = head[W-1 -: AW];
        eng_dst      = head[W-AW-1 -: AW];
        eng_len      = head[LW-1:0];
        pop          = (st == L_RUN) && eng_done;
        seg_done     = pop;
        seg_len      = head[LW-1:0];
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !eng_busy); // R7
    AST_WARM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_warm_rst |-> !eng_busy); // R7
    AST_START_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        eng_warm_rst |=> !eng_start); // R7

endmodule

// File: rtl/lcs_tracker.sv
module lcs_tracker #(
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic [LW-1:0] req_len,
    input  logic          seg_done,
    input  logic [LW-1:0] seg_len,
    output logic [LW-1:0] residue,
    output logic          cmp_done
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            residue  <= '0;
            cmp_done <= 1'b0;
        end else begin
            if (acc)           residue <= req_len;
            else if (seg_done) residue <= residue - seg_len;
            cmp_done <= (acc && req_len == '0) || (seg_done && seg_len == residue);
        end
    end

    AST_NO_RESIDUE_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |-> (seg_len <= residue)); // R4
    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |-> (residue == '0)); // R5

endmodule

// File: rtl/long_copy_splitter.sv
module long_copy_splitter #(
    parameter int          AW      = 32,
    parameter int          LW      = 32,
    parameter int unsigned SEG_MAX = 268435455,
    parameter int          QDEPTH  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_src,
    input  logic [AW-1:0] req_dst,
    input  logic [LW-1:0] req_len,
    output logic          eng_warm_rst,
    output logic          eng_start,
    output logic [AW-1:0] eng_src,
    output logic [AW-1:0] eng_dst,
    output logic [LW-1:0] eng_len,
    input  logic          eng_busy,
    input  logic          eng_done,
    output logic          cmp_done,
    output logic [LW-1:0] residue
);
    localparam int W = 2 * AW + LW;

    logic         acc, sp_idle, push, pop;
    logic         q_empty, q_full, q_multi;
    logic [W-1:0] seg_w, head;
    logic         seg_done;
    logic [LW-1:0] done_len;

    always_comb begin
        req_ready = sp_idle && (residue == '0);
        acc       = req_valid && req_ready;
    end

    lcs_splitter #(.AW(AW), .LW(LW), .SEG_MAX(SEG_MAX)) u_split (
        .clk(clk), .rst_n(rst_n), .acc(acc),
        .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .q_full(q_full), .push(push), .seg_data(seg_w), .idle(sp_idle)
    );

    lcs_seg_fifo #(.W(W), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(seg_w),
        .pop(pop), .rdata(head), .empty(q_empty), .full(q_full), .multi(q_multi)
    );

    lcs_launcher #(.AW(AW), .LW(LW)) u_launch (
        .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_multi(q_multi),
        .head(head), .pop(pop), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_warm_rst(eng_warm_rst), .eng_start(eng_start),
        .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len),
        .seg_done(seg_done), .seg_len(done_len)
    );

    lcs_tracker #(.LW(LW)) u_track (
        .clk(clk), .rst_n(rst_n), .acc(acc), .req_len(req_len),
        .seg_done(seg_done), .seg_len(done_len),
        .residue(residue), .cmp_done(cmp_done)
    );

    AST_READY_LOW_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_len != '0) |=> !req_ready); // R9
    AST_ZERO_LEN_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_len == '0) |=> cmp_done); // R8

endmodule

// File: tb/test_long_copy_splitter.sv
`timescale 1ns/1ps
module test_long_copy_splitter;
    localparam int AW  = 32;
    localparam int LW  = 32;
    localparam int SEG = 16;
    localparam int QD  = 2;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_src = '0, req_dst = '0;
    logic [LW-1:0] req_len = '0;
    logic          eng_warm_rst, eng_start;
    logic [AW-1:0] eng_src, eng_dst;
    logic [LW-1:0] eng_len;
    logic          eng_busy;
    logic          eng_done;
    logic          cmp_done;
    logic [LW-1:0] residue;

    always #5 clk = ~clk;

    long_copy_splitter #(.AW(AW), .LW(LW), .SEG_MAX(SEG), .QDEPTH(QD)) i_long_copy_splitter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .eng_warm_rst(eng_warm_rst), .eng_start(eng_start),
        .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len),
        .eng_busy(eng_busy), .eng_done(eng_done),
        .cmp_done(cmp_done), .residue(residue)
    );

    // engine model and observers
    int wcnt, rcnt, nstart, ndone, ncmp, ndone_at_cmp, bad_busy, bad_warm, nwarm;
    logic warm_seen;
    logic [31:0] st_src [128];
    logic [31:0] st_dst [128];
    logic [31:0] st_len [128];
    logic [31:0] res_b  [128];

    assign eng_busy = (wcnt != 0) || (rcnt != 0);

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0; rcnt <= 0; eng_done <= 1'b0; warm_seen <= 1'b0;
            nstart <= 0; ndone <= 0; ncmp <= 0; ndone_at_cmp <= 0;
            bad_busy <= 0; bad_warm <= 0; nwarm <= 0;
        end else begin
            eng_done <= 1'b0;
            if (eng_warm_rst) begin
                wcnt <= 2; warm_seen <= 1'b1; nwarm <= nwarm + 1;
                if (eng_busy) bad_busy <= bad_busy + 1;
            end else if (wcnt > 0) wcnt <= wcnt - 1;
            if (eng_start) begin
                if (nstart < 128) begin
                    st_src[nstart] <= eng_src;
                    st_dst[nstart] <= eng_dst;
                    st_len[nstart] <= eng_len;
                end
                nstart <= nstart + 1;
                rcnt <= LAT;
                if (eng_busy) bad_busy <= bad_busy + 1;
                if (!warm_seen) bad_warm <= bad_warm + 1;
                warm_seen <= 1'b0;
            end else if (rcnt > 0) begin
                rcnt <= rcnt - 1;
                if (rcnt == 1) eng_done <= 1'b1;
            end
            if (eng_done) begin
                if (ndone < 128) res_b[ndone] <= residue;
                ndone <= ndone + 1;
            end
            if (cmp_done) begin
                ncmp <= ncmp + 1;
                ndone_at_cmp <= ndone;
            end
        end
    end

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one request; optionally present an intruding request while busy
    task automatic run_req(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                           input bit intrude);
        int base_s, base_c, nseg, off, rem, exp_len, guard;
        bit ready_stayed_low;
        base_s = nstart;
        base_c = ncmp;
        nseg = (l + SEG - 1) / SEG;
        @(negedge clk);
        req_valid = 1'b1; req_src = s; req_dst = d; req_len = l;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(residue == l, "R4 residue after accept", residue, l);
        if (l != 0) chk(req_ready == 1'b0, "R9 ready low in flight", req_ready, 0);
        if (intrude) begin
            ready_stayed_low = 1'b1;
            req_valid = 1'b1; req_src = 32'hDEAD_0000; req_dst = 32'hBEEF_0000; req_len = 7;
            for (int i = 0; i < 10; i++) begin
                if (req_ready) ready_stayed_low = 1'b0;
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk(ready_stayed_low, "R9 ready stays low", ready_stayed_low, 1);
        end
        guard = 0;
        while (ncmp == base_c && guard < 4000) begin @(negedge clk); guard++; end
        wait_cycles(20);
        chk(ncmp == base_c + 1, "R5 one completion pulse", ncmp - base_c, 1);
        chk(nstart - base_s == nseg, "R1 segment count", nstart - base_s, nseg);
        if (l != 0)
            chk(ndone_at_cmp == base_s + nseg, "R5 completion after last segment",
                ndone_at_cmp, base_s + nseg);
        off = 0;
        rem = l;
        for (int k = 0; k < nseg && k < (nstart - base_s); k++) begin
            exp_len = (rem > SEG) ? SEG : rem;
            chk(st_len[base_s+k] == exp_len, "R2 segment length", st_len[base_s+k], exp_len);
            chk(st_src[base_s+k] == s + off, "R3 segment source", st_src[base_s+k], s + off);
            chk(st_dst[base_s+k] == d + off, "R3 segment destination", st_dst[base_s+k], d + off);
            chk(res_b[base_s+k] == l - off, "R4 residue at completion", res_b[base_s+k], l - off);
            off += exp_len;
            rem -= exp_len;
        end
        chk(bad_busy == 0, "R6 no start while busy", bad_busy, 0);
        chk(bad_warm == 0, "R7 warm reset before start", bad_warm, 0);
        chk(req_ready == 1'b1, "R9 ready after completion", req_ready, 1);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
        chk(residue == 0, "R10 residue after reset", residue, 0);
        chk(cmp_done == 1'b0, "R10 cmp_done after reset", cmp_done, 0);
        chk(eng_start == 1'b0 && eng_warm_rst == 1'b0, "R10 engine quiet", eng_start, 0);
    endtask

    task automatic t_zero_len;
        int s0, w0;
        s0 = nstart;
        w0 = nwarm;
        @(negedge clk);
        req_valid = 1'b1; req_src = 32'h40; req_dst = 32'h80; req_len = 0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmp_done == 1'b1, "R8 zero length completes next cycle", cmp_done, 1);
        @(negedge clk);
        chk(cmp_done == 1'b0, "R8 single pulse", cmp_done, 0);
        wait_cycles(20);
        chk(nstart == s0, "R8 no engine start", nstart - s0, 0);
        chk(nwarm == w0, "R8 no warm reset", nwarm - w0, 0);
    endtask

    initial begin
        wait_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_req(32'h0000_1000, 32'h0000_8000, 40, 1'b0);   // short tail
        run_req(32'h0000_2000, 32'h0001_0000, 32, 1'b0);   // exact multiple
        run_req(32'h0000_3003, 32'h0002_0005, 5, 1'b0);    // below one segment
        t_zero_len();
        run_req(32'h0010_0000, 32'h0020_0000, 115, 1'b0);  // queue full stalls, R1
        run_req(32'h0000_5000, 32'h0000_9000, 40, 1'b1);   // intruding request ignored, R9
        run_req(32'hFFFF_FFF0, 32'h0000_0010, 17, 1'b0);   // address wrap
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule